// File: doc/BRIEF.md
# Debug Monitor Entry and Clock Selector

This block makes the single boot-time decision on whether the device starts in its serial debug monitor or in normal user mode. It also settles how far the external clock is divided to form the bus clock. Shortly after power-on reset is released, it looks at three things: the two reset-vector bytes read from nonvolatile memory, a qualified flag saying that a high test voltage is present on the interrupt pin, and a mode-select pin. From these it fixes a configuration that holds until the next power-on reset.

An erased reset vector lets the monitor start without the high voltage. A programmed vector needs the high-voltage flag. Each accepted entry case assumes a particular external clock frequency, and the divide ratio is chosen so that the bus always runs at the same rate. This keeps the serial bit rate of the monitor constant. The block drives a bus clock enable at the chosen ratio, and a bit-rate tick derived from that enable for the serial port. It also raises a flag when entry happened through the erased-vector path, so that security logic downstream can act on it.

Top module: `mon_entry_ctl`

## Requirements
- R1: The vector counts as erased only when both the high and the low vector byte read 8'hFF. Any other value in either byte counts as programmed.
- R2: With an erased vector, `mon_active`=1, `blank_entry`=1 and `div_fast`=0 (divide by 4), whatever the levels of the high-voltage flag and the select pin.
- R3: With a programmed vector, the high-voltage flag set and the select pin low, `mon_active`=1, `div_fast`=1 (divide by 2) and `blank_entry`=0.
- R4: With a programmed vector, the high-voltage flag set and the select pin high, `mon_active`=1, `div_fast`=0 and `blank_entry`=0.
- R5: With a programmed vector and the high-voltage flag clear, the block starts user mode: `mon_active`=0, `blank_entry`=0, `div_fast`=0.
- R6: The select pin and the high-voltage flag each pass through a two-flop synchronizer. The decision is taken on the third rising clock edge after `por_n` goes high, and `cfg_valid` rises there. After that, the outputs ignore every input change until `por_n` is next driven low.
- R7: `bus_ce` stays low until `cfg_valid` is set. It then pulses for one clock in every 2 clocks when `div_fast`=1, and in every 4 clocks when `div_fast`=0.
- R8: `baud_tick` pulses only together with a `bus_ce` pulse, once in every 278 bus-enable pulses.
- R9: While `por_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| vec_hi | input | 8 | Reset-vector high byte from nonvolatile memory |
| vec_lo | input | 8 | Reset-vector low byte from nonvolatile memory |
| hv_flag | input | 1 | Qualified high-voltage detect on the interrupt pin (asynchronous) |
| sel_pin | input | 1 | Mode-select pin, asynchronous |
| cfg_valid | output | 1 | Boot decision has been taken |
| mon_active | output | 1 | Device runs the debug monitor |
| div_fast | output | 1 | 1: bus = clock/2, 0: bus = clock/4 |
| blank_entry | output | 1 | Monitor entered through the erased-vector path |
| bus_ce | output | 1 | Bus clock enable |
| baud_tick | output | 1 | Serial bit-rate tick |

## Verification
On every cycle, the embedded properties hold the latched decision stable once it is valid. They also keep `bus_ce` quiet before the decision, forbid back-to-back enables, tie every bit-rate tick to an enable pulse, and make the erased-vector flag imply monitor mode. Only the bench scenarios can show the following: that each combination of vector bytes, high-voltage flag and select level maps to the right mode and ratio; that the decision lands exactly on the third edge after reset; and that the enable and tick periods come out at 2 or 4 and 278 times that.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

   typedef struct packed {
      logic mon;
      logic fast;
      logic blank;
   } mon_cfg_t;

   localparam mon_cfg_t CFG_USER = '{mon: 1'b0, fast: 1'b0, blank: 1'b0};

endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mon_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/mon_entry_decide.sv
module mon_entry_decide
   import mon_entry_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int SETTLE      = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [VEC_W-1:0] vec_hi,
   input  logic [VEC_W-1:0] vec_lo,
   input  logic             hv_s,
   input  logic             sel_s,
   output logic             cfg_valid,
   output mon_cfg_t         cfg
);

   localparam int CNT_W = $clog2(SETTLE + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE);

   if (VEC_W < 1) begin : g_bad_vec
      $error("mon_entry_decide: VEC_W must be positive");
   end

   logic [CNT_W-1:0] settle_cnt;
   logic             erased;
   mon_cfg_t         next_cfg;

   assign erased = (&vec_hi) && (&vec_lo);

   always_comb begin
      next_cfg = CFG_USER;
      if (erased) begin
         next_cfg.mon   = 1'b1;
         next_cfg.blank = 1'b1;
      end else if (hv_s) begin
         next_cfg.mon  = 1'b1;
         next_cfg.fast = !sel_s;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         settle_cnt <= '0;
         cfg_valid  <= 1'b0;
         cfg        <= CFG_USER;
      end else if (!cfg_valid) begin
         if (settle_cnt == LAST) begin
            cfg_valid <= 1'b1;
            cfg       <= next_cfg;
         end else begin
            settle_cnt <= settle_cnt + 1'b1;
         end
      end
   end

   // R6
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (cfg_valid && $past(cfg_valid)) |-> $stable(cfg));
   // R6
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      $past(cfg_valid) |-> cfg_valid);
   // R2
   blank_mon_chk: assert property (@(posedge clk) disable iff (!por_n)
      cfg.blank |-> (cfg.mon && !cfg.fast));
   // R5
   fast_needs_mon_chk: assert property (@(posedge clk) disable iff (!por_n)
      cfg.fast |-> cfg.mon);

endmodule

// File: rtl/mon_clk_div.sv
module mon_clk_div #(
   parameter int DIV_FAST = 2,
   parameter int DIV_SLOW = 4,
   parameter int BAUD_DIV = 278
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   input  logic fast,
   output logic bus_ce,
   output logic baud_tick
);

   localparam int MAX_DIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
   localparam int CNT_W   = $clog2(MAX_DIV);
   localparam int BAUD_W  = $clog2(BAUD_DIV);
   localparam logic [CNT_W-1:0]  FAST_LAST = CNT_W'(DIV_FAST - 1);
   localparam logic [CNT_W-1:0]  SLOW_LAST = CNT_W'(DIV_SLOW - 1);
   localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(BAUD_DIV - 1);

   if (DIV_FAST < 2 || DIV_SLOW < 2) begin : g_bad_div
      $error("mon_clk_div: divide ratios must be at least 2");
   end
   if (BAUD_DIV < 2) begin : g_bad_baud
      $error("mon_clk_div: BAUD_DIV must be at least 2");
   end

   logic [CNT_W-1:0]  div_cnt;
   logic [CNT_W-1:0]  div_last;
   logic [BAUD_W-1:0] baud_cnt;

   assign div_last  = fast ? FAST_LAST : SLOW_LAST;
   assign bus_ce    = run && (div_cnt == div_last);
   assign baud_tick = bus_ce && (baud_cnt == BAUD_LAST);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         div_cnt <= '0;
      end else if (run) begin
         div_cnt <= bus_ce ? '0 : div_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         baud_cnt <= '0;
      end else if (bus_ce) begin
         baud_cnt <= baud_tick ? '0 : baud_cnt + 1'b1;
      end
   end

   // R7
   ce_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
      !run |-> !bus_ce);
   // R7
   ce_gap_chk: assert property (@(posedge clk) disable iff (!por_n)
      bus_ce |=> !bus_ce);
   // R8
   tick_on_ce_chk: assert property (@(posedge clk) disable iff (!por_n)
      baud_tick |-> bus_ce);

endmodule

// File: rtl/mon_entry_ctl.sv
module mon_entry_ctl
   import mon_entry_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_FAST    = 2,
   parameter int DIV_SLOW    = 4,
   parameter int BAUD_DIV    = 278
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [VEC_W-1:0] vec_hi,
   input  logic [VEC_W-1:0] vec_lo,
   input  logic             hv_flag,
   input  logic             sel_pin,
   output logic             cfg_valid,
   output logic             mon_active,
   output logic             div_fast,
   output logic             blank_entry,
   output logic             bus_ce,
   output logic             baud_tick
);

   logic     hv_s;
   logic     sel_s;
   mon_cfg_t cfg;

   mon_sync #(.STAGES(SYNC_STAGES)) i_hv_sync (
      .clk(clk), .rst_n(por_n), .d(hv_flag), .q(hv_s)
   );

   mon_sync #(.STAGES(SYNC_STAGES)) i_sel_sync (
      .clk(clk), .rst_n(por_n), .d(sel_pin), .q(sel_s)
   );

   mon_entry_decide #(.VEC_W(VEC_W), .SETTLE(SYNC_STAGES)) i_decide (
      .clk(clk), .por_n(por_n), .vec_hi(vec_hi), .vec_lo(vec_lo),
      .hv_s(hv_s), .sel_s(sel_s), .cfg_valid(cfg_valid), .cfg(cfg)
   );

   mon_clk_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .BAUD_DIV(BAUD_DIV)) i_div (
      .clk(clk), .por_n(por_n), .run(cfg_valid), .fast(cfg.fast),
      .bus_ce(bus_ce), .baud_tick(baud_tick)
   );

   assign mon_active  = cfg.mon;
   assign div_fast    = cfg.fast;
   assign blank_entry = cfg.blank;

   // R2
   blank_out_chk: assert property (@(posedge clk) disable iff (!por_n)
      blank_entry |-> mon_active);

endmodule

// File: tb/test_mon_entry_ctl.sv
module test_mon_entry_ctl;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [7:0] vec_hi = 8'h00, vec_lo = 8'h00;
   logic       hv_flag = 1'b0, sel_pin = 1'b0;
   logic       cfg_valid, mon_active, div_fast, blank_entry, bus_ce, baud_tick;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mon_entry_ctl i_mon_entry_ctl (
      .clk(clk), .por_n(por_n), .vec_hi(vec_hi), .vec_lo(vec_lo),
      .hv_flag(hv_flag), .sel_pin(sel_pin), .cfg_valid(cfg_valid),
      .mon_active(mon_active), .div_fast(div_fast), .blank_entry(blank_entry),
      .bus_ce(bus_ce), .baud_tick(baud_tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit f_erased(input logic [7:0] h, input logic [7:0] l);
      return (h == 8'hFF) && (l == 8'hFF);
   endfunction
   function automatic bit f_mon(input logic [7:0] h, input logic [7:0] l, input bit hv);
      return f_erased(h, l) || hv;
   endfunction
   function automatic bit f_fast(input logic [7:0] h, input logic [7:0] l, input bit hv, input bit sel);
      return !f_erased(h, l) && hv && !sel;
   endfunction

   task automatic run_case(input logic [7:0] h, input logic [7:0] l, input bit hv,
                           input bit sel, input bit do_baud);
      bit em, ef, eb;
      int n, gap;
      em = f_mon(h, l, hv);
      ef = f_fast(h, l, hv, sel);
      eb = f_erased(h, l);
      @(negedge clk);
      por_n = 1'b0;
      vec_hi = h; vec_lo = l; hv_flag = hv; sel_pin = sel;
      repeat (3) @(negedge clk);
      chk({cfg_valid, mon_active, div_fast, blank_entry, bus_ce, baud_tick} == 6'b0,
          "R9 outputs in reset", {cfg_valid, mon_active, div_fast, blank_entry, bus_ce, baud_tick}, 0);
      por_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cfg_valid == 1'b0 && bus_ce == 1'b0, "R6/R7 early valid", {cfg_valid, bus_ce}, 0);
      @(negedge clk);
      chk(cfg_valid == 1'b1, "R6 valid on third edge", cfg_valid, 1);
      chk(mon_active == em, "R1/R2/R3/R4/R5 mon_active", mon_active, em);
      chk(div_fast == ef, "R2/R3/R4/R5 div_fast", div_fast, ef);
      chk(blank_entry == eb, "R1/R2 blank_entry", blank_entry, eb);
      vec_hi = $urandom(); vec_lo = $urandom(); hv_flag = !hv; sel_pin = !sel;
      n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (bus_ce) n++;
      end
      chk(n == (ef ? 20 : 10), "R7 enable count", n, ef ? 20 : 10);
      chk({mon_active, div_fast, blank_entry} == {em, ef, eb}, "R6 held after input change",
          {mon_active, div_fast, blank_entry}, {em, ef, eb});
      if (do_baud) begin
         n = 0;
         while (!baud_tick && n < 3000) begin @(negedge clk); n++; end
         gap = 0;
         @(negedge clk);
         gap = 1;
         while (!baud_tick && gap < 3000) begin @(negedge clk); gap++; end
         chk(gap == 278 * (ef ? 2 : 4), "R8 tick period", gap, 278 * (ef ? 2 : 4));
      end
   endtask

   initial begin
      void'($urandom(32'h5EED));
      // directed corners
      run_case(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1); // R2 erased, no voltage
      run_case(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0); // R2 erased, voltage and select ignored
      run_case(8'hFF, 8'hFE, 1'b0, 1'b0, 1'b0); // R1 one byte programmed
      run_case(8'h7F, 8'hFF, 1'b0, 1'b1, 1'b0); // R1
      run_case(8'h12, 8'h34, 1'b1, 1'b0, 1'b1); // R3
      run_case(8'h12, 8'h34, 1'b1, 1'b1, 1'b0); // R4
      run_case(8'h00, 8'h00, 1'b0, 1'b1, 1'b0); // R5
      for (int k = 0; k < 30; k++) begin
         logic [7:0] h, l;
         if ($urandom_range(2) == 0) begin h = 8'hFF; l = 8'hFF; end
         else begin h = $urandom(); l = $urandom(); end
         run_case(h, l, 1'($urandom_range(1)), 1'($urandom_range(1)), 1'b0);
      end
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule